// File: doc/BRIEF.md
# Planar Video Pixel Serializer

This block turns the four plane bytes that a display fetch returns into a stream of pixels for the attribute stage. A load strobe captures all four bytes in one cycle, and every cycle in which the pixel-clock enable is high then advances the stream by one pixel. Two mode inputs choose between three layouts: parallel planar (one bit from each plane per pixel), packed two-bit-per-pixel for four-colour modes, and a wide layout that pairs consecutive nibbles into eight-bit pixels.

In the planar and wide layouts the four plane shifters are linked end to end. Plane 3's outgoing bit enters plane 2, plane 2's enters plane 1, and plane 1's enters plane 0. Bit 0 of the pixel output therefore also serves as a 32-pixel, one-bit-per-pixel source when the downstream stage masks off planes 1 to 3. The wide-mode input overrides the packed-mode input.

Top module: `planar_pixel_serializer`

## Requirements
- R1: While reset is asserted, `pix4` and `pix8` are zero, and all plane shifters are cleared.
- R2: A clock edge with `load` high captures all four bytes of `plane_data` (plane p in bits 8p+7..8p). The first pixel of the new data is visible right after that edge.
- R3: With `load` and `pix_en` both low, an edge leaves `pix4` and `pix8` unchanged as long as the mode inputs are unchanged.
- R4: Planar layout (`mode_wide`=0, `mode_pack`=0): `pix4` bit p is the current most significant bit of plane p. The planes shift MSB first, one bit per enabled edge.
- R5: In the planar and wide layouts the shifters form one chain. After k advances (k < 32), `pix4` bit 0 equals bit 7-(k mod 8) of plane k/8. Once the chain is exhausted, zeros follow.
- R6: Packed layout (`mode_wide`=0, `mode_pack`=1): after k advances, `pix4[1:0]` is bits 7-2k and 6-2k of plane 0, and `pix4[3:2]` is the same two bits of plane 2. Four pixels come per byte pair, and zeros come after that.
- R7: With `mode_wide`=1 the wide layout is used whatever `mode_pack` is, and `pix4` then follows the planar rule of R4 and R5.
- R8: In the wide layout, `pix8` becomes {earlier nibble, later nibble} on every second advance after a load, and holds that value for two advances. `pix8` is zero whenever `mode_wide` is 0.
- R9: `load` takes priority over `pix_en` on the same edge. It also restarts the nibble pairing and clears `pix8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture the four plane bytes |
| pix_en | input | 1 | Advance the stream by one pixel |
| mode_wide | input | 1 | Select the 8-bit paired-nibble layout (priority) |
| mode_pack | input | 1 | Select the packed 2-bit layout when `mode_wide` is 0 |
| plane_data | input | 32 | Plane bytes, plane p in bits 8p+7..8p |
| pix4 | output | 4 | Current 4-bit pixel |
| pix8 | output | 8 | Paired 8-bit pixel, zero outside the wide layout |

## Verification
Some properties are checked on every cycle by the assertions. These are: outputs hold while idle, and `pix8` stays zero outside the wide layout. A load in the planar or wide layout exposes the plane MSBs on the next edge. A load also clears `pix8`. The bench's sweeps are needed for the rest: the 32-step chain order across planes, the packed two-bit extraction and its end, and the two-advance cadence of the nibble pairs. The same sweeps confirm that the wide input overrides the packed input.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [1:0] {
      LAY_PLANAR = 2'd0,
      LAY_PACKED = 2'd1,
      LAY_WIDE   = 2'd2
   } layout_e;

   // wide input overrides the packed input
   function automatic layout_e pick_layout(input logic wide, input logic pack);
      if (wide)
         return LAY_WIDE;
      else if (pack)
         return LAY_PACKED;
      else
         return LAY_PLANAR;
   endfunction

endpackage

// File: rtl/pps_plane_shifter.sv
module pps_plane_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              adv,
   input  logic              two_step,
   input  logic              link_in,
   input  logic [BYTE_W-1:0] ld_val,
   output logic              top_bit,
   output logic              next_bit
);

   logic [BYTE_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (ld)
         sr_q <= ld_val;
      else if (adv) begin
         if (two_step)
            sr_q <= {sr_q[BYTE_W-3:0], 2'b00};
         else
            sr_q <= {sr_q[BYTE_W-2:0], link_in};
      end
   end

   assign top_bit  = sr_q[BYTE_W-1];
   assign next_bit = sr_q[BYTE_W-2];

endmodule

// File: rtl/pps_pixel_mux.sv
module pps_pixel_mux
   import pps_pkg::*;
#(
   parameter int PLANES = 4
) (
   input  layout_e           lay,
   input  logic [PLANES-1:0] tops,
   input  logic [PLANES-1:0] nexts,
   output logic [PLANES-1:0] pix
);

   localparam int PAIRS = PLANES / 2;

   logic [PLANES-1:0] packed_pix;

   generate
      for (genvar g = 0; g < PAIRS; g++) begin : g_pair
         // each pair of output bits comes from the even plane of the pair
         assign packed_pix[2*g+1] = tops[2*g];
         assign packed_pix[2*g]   = nexts[2*g];
      end
   endgenerate

   always_comb begin
      unique case (lay)
         LAY_PACKED: pix = packed_pix;
         default:    pix = tops;
      endcase
   end

endmodule

// File: rtl/pps_wide_pair.sv
module pps_wide_pair #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld,
   input  logic               adv,
   input  logic               en,
   input  logic [NIB_W-1:0]   nib,
   output logic [2*NIB_W-1:0] wide_pix
);

   logic               second_q;
   logic [NIB_W-1:0]   first_q;
   logic [2*NIB_W-1:0] pair_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_q <= 1'b0;
         first_q  <= '0;
         pair_q   <= '0;
      end else if (ld) begin
         second_q <= 1'b0;
         first_q  <= '0;
         pair_q   <= '0;
      end else if (adv && en) begin
         if (!second_q) begin
            first_q  <= nib;
            second_q <= 1'b1;
         end else begin
            pair_q   <= {first_q, nib};
            second_q <= 1'b0;
         end
      end
   end

   assign wide_pix = en ? pair_q : '0;

endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer
   import pps_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     pix_en,
   input  logic                     mode_wide,
   input  logic                     mode_pack,
   input  logic [PLANES*BYTE_W-1:0] plane_data,
   output logic [PLANES-1:0]        pix4,
   output logic [2*PLANES-1:0]      pix8
);

   generate
      if (PLANES != 4) begin : g_bad_planes
         $error("planar_pixel_serializer: PLANES must be 4");
      end
      if (BYTE_W < 4 || (BYTE_W % 2) != 0) begin : g_bad_width
         $error("planar_pixel_serializer: BYTE_W must be even and at least 4");
      end
   endgenerate

   layout_e           lay;
   logic              two_step;
   logic [PLANES-1:0] tops;
   logic [PLANES-1:0] nexts;
   logic [PLANES-1:0] links;

   assign lay      = pick_layout(mode_wide, mode_pack);
   assign two_step = (lay == LAY_PACKED);

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_plane
         if (p == PLANES - 1) begin : g_end
            assign links[p] = 1'b0;
         end else begin : g_mid
            assign links[p] = tops[p+1];
         end

         pps_plane_shifter #(.BYTE_W(BYTE_W)) u_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld       (load),
            .adv      (pix_en),
            .two_step (two_step),
            .link_in  (links[p]),
            .ld_val   (plane_data[p*BYTE_W +: BYTE_W]),
            .top_bit  (tops[p]),
            .next_bit (nexts[p])
         );
      end
   endgenerate

   pps_pixel_mux #(.PLANES(PLANES)) u_mux (
      .lay   (lay),
      .tops  (tops),
      .nexts (nexts),
      .pix   (pix4)
   );

   pps_wide_pair #(.NIB_W(PLANES)) u_wide (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (load),
      .adv      (pix_en),
      .en       (lay == LAY_WIDE),
      .nib      (tops),
      .wide_pix (pix8)
   );

endmodule

// File: rtl/planar_pixel_serializer_chk.sv
module planar_pixel_serializer_chk #(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     load,
   input logic                     pix_en,
   input logic                     mode_wide,
   input logic                     mode_pack,
   input logic [PLANES*BYTE_W-1:0] plane_data,
   input logic [PLANES-1:0]        pix4,
   input logic [2*PLANES-1:0]      pix8
);

   function automatic logic [PLANES-1:0] msbs(input logic [PLANES*BYTE_W-1:0] d);
      logic [PLANES-1:0] r;
      for (int p = 0; p < PLANES; p++) r[p] = d[p*BYTE_W + BYTE_W - 1];
      return r;
   endfunction

   // R3: idle edges keep both outputs when modes do not move
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !pix_en) |=> (!$stable({mode_wide, mode_pack}) ||
                              ($stable(pix4) && $stable(pix8))));

   // R8: wide output silent outside the wide layout
   a_r8_wide_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wide |-> (pix8 == '0));

   // R2, R4: load in planar layout shows plane MSBs next cycle
   a_r2_planar_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !mode_wide && !mode_pack) |=>
         (!$stable({mode_wide, mode_pack}) || pix4 == msbs($past(plane_data))));

   // R7: wide input overrides packed input after a load
   a_r7_wide_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode_wide) |=>
         (!$stable({mode_wide, mode_pack}) || pix4 == msbs($past(plane_data))));

   // R9: a load clears the paired output
   a_r9_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pix8 == '0));

endmodule

bind planar_pixel_serializer planar_pixel_serializer_chk #(
   .PLANES(PLANES),
   .BYTE_W(BYTE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load       (load),
   .pix_en     (pix_en),
   .mode_wide  (mode_wide),
   .mode_pack  (mode_pack),
   .plane_data (plane_data),
   .pix4       (pix4),
   .pix8       (pix8)
);

// File: tb/planar_pixel_serializer_test.sv
module planar_pixel_serializer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        pix_en = 1'b0;
   logic        mode_wide = 1'b0;
   logic        mode_pack = 1'b0;
   logic [31:0] plane_data = '0;
   logic [3:0]  pix4;
   logic [7:0]  pix8;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   planar_pixel_serializer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .pix_en     (pix_en),
      .mode_wide  (mode_wide),
      .mode_pack  (mode_pack),
      .plane_data (plane_data),
      .pix4       (pix4),
      .pix8       (pix8)
   );

   function automatic logic chain_bit(input logic [31:0] d, input int p, input int k);
      int idx = p * 8 + k;
      if (idx >= 32) return 1'b0;
      return d[(idx / 8) * 8 + 7 - (idx % 8)];
   endfunction

   function automatic logic [3:0] nib_at(input logic [31:0] d, input int k);
      logic [3:0] r;
      for (int p = 0; p < 4; p++) r[p] = chain_bit(d, p, k);
      return r;
   endfunction

   function automatic logic [3:0] exp_pix4(input logic [31:0] d, input int w,
                                           input int pk, input int k);
      if (w == 0 && pk == 1) begin
         if (k >= 4) return 4'h0;
         return {d[16 + 7 - 2*k], d[16 + 6 - 2*k], d[7 - 2*k], d[6 - 2*k]};
      end
      return nib_at(d, k);
   endfunction

   function automatic logic [7:0] exp_pix8(input logic [31:0] d, input int w, input int k);
      int j;
      if (w == 0 || k < 2) return 8'h00;
      j = (k / 2) * 2;
      return {nib_at(d, j - 2), nib_at(d, j - 1)};
   endfunction

   task automatic check(input string req, input logic [3:0] e4, input logic [7:0] e8);
      vectors++;
      if (pix4 !== e4 || pix8 !== e8) begin
         errors++;
         $display("FAIL %s: pix4=%h pix8=%h expected pix4=%h pix8=%h", req, pix4, pix8, e4, e8);
      end
   endtask

   task automatic run_pattern(input logic [31:0] d, input int w, input int pk);
      string req;
      req = (w == 1) ? "R7/R8" : (pk == 1) ? "R6" : "R4/R5";
      @(negedge clk);
      plane_data = d; mode_wide = w[0]; mode_pack = pk[0];
      load = 1'b1; pix_en = 1'b1;            // R9: load wins over advance
      @(negedge clk);
      load = 1'b0; pix_en = 1'b0;
      check("R2/R9", exp_pix4(d, w, pk, 0), exp_pix8(d, w, 0));
      plane_data = ~d;                        // must not be captured
      for (int k = 1; k <= 34; k++) begin
         pix_en = 1'b1;
         @(negedge clk);
         pix_en = 1'b0;
         check(req, exp_pix4(d, w, pk, k), exp_pix8(d, w, k));
         if (k % 3 == 0) begin
            @(negedge clk);
            check("R3", exp_pix4(d, w, pk, k), exp_pix8(d, w, k));
         end
      end
   endtask

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2357;
      #1;
      @(negedge clk);
      check("R1", 4'h0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      // fixed corner patterns
      for (int m = 0; m < 4; m++) begin
         run_pattern(32'hFFFF_FFFF, m / 2, m % 2);
         run_pattern(32'h8000_0001, m / 2, m % 2);
         run_pattern(32'h0123_4567, m / 2, m % 2);
      end
      // pseudo-random sweep across all mode combinations
      for (int n = 0; n < 24; n++) begin
         for (int m = 0; m < 4; m++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_pattern(lfsr ^ (lfsr << 7), m / 2, m % 2);
         end
      end
      // R1: reset in mid-stream clears everything
      run_pattern(32'hDEAD_BEEF, 1, 0);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1", 4'h0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 4'h0, 8'h00);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule